// File: doc/BRIEF.md
# SPI Mode-0 Register Slave

This block lets an external SPI master read and write a small register file. It works in SPI mode 0 only: SCLK idles low, the master drives MOSI, the slave samples it on the rising SCLK edge, and the slave changes MISO on the falling edge. The block has no clock of its own on the serial side. SCLK, chip select and MOSI are brought into the system clock domain through two-flop synchronizers, and the SCLK edges are detected there. The system clock must therefore run several times faster than SCLK.

Each transaction is framed by an active-low chip select. The first byte is a command:
- Bit 7 selects the direction: 1 for a read, 0 for a write.
- Bits 6:3 give the register index.
- Bits 2:1 must be zero.
- Bit 0 is don't-care.

For a write, the next byte goes to the selected register. For a read, the selected register's value is shifted out on MISO. The block drives the same register access port that the other host front end uses. That port consists of a one-cycle write strobe, a one-cycle read strobe, an index, write data and combinational read data.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset the following outputs are all low: `reg_wr_o`, `reg_rd_o`, `spi_miso_o`, and `reg_addr_o`. While chip select is high, `spi_miso_oe_o` is also low.
- R2: `spi_miso_oe_o` is high exactly while `spi_csn_i` is low. The high-impedance state is this enable being low.
- R3: Bits are sampled on rising SCLK edges, MSB first. In the command byte, bit 7 = 1 means read and 0 means write, and bits 6:3 are the register index placed on `reg_addr_o`. Bit 0 is ignored.
- R4: For a write command, `reg_wr_o` pulses for exactly one cycle after the eighth data bit arrives. During that cycle `reg_addr_o` holds the index and `reg_wdata_o` holds the data byte.
- R5: For a read command, `reg_rd_o` pulses once. The selected register's value then appears on MISO MSB first. Bit 7 is valid after the falling SCLK edge that ends the command byte, and each later falling edge presents the next bit.
- R6: A command whose bits 2:1 are not both zero is rejected. It produces no write strobe and no read strobe, and a rejected read shifts out 0x00.
- R7: If chip select rises before a byte is complete, the partial byte is discarded. No write happens, and the next transaction starts with a fresh command byte.
- R8: Within one chip-select frame, bits after the first data byte are ignored. They cause no second write, and MISO reads 0 after the eighth data bit of a read.
- R9: SCLK activity while chip select is high has no effect on the registers or on the framing of the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_sclk_i | input | 1 | SPI serial clock, idle low |
| spi_csn_i | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | Serial data from master |
| spi_miso_o | output | 1 | Serial data to master |
| spi_miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| reg_addr_o | output | 4 | Register index from the command byte |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Data byte for the write |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Register value for the current index |

## Verification
A wrong bit counter or phase register does not stay hidden. Within the same frame it either shifts the MISO byte by one or more positions or moves the write strobe off the eighth data bit. It can also produce a write with a stale or partial byte, which the next readback of that register exposes. Stale framing that survives a chip-select rise shows up on the very next transaction, as a misread command. Register corruption is caught by a full write-then-read sweep over all sixteen indices, using values the bench computes from the index.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  parameter int unsigned IDX_W = 4;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  typedef struct packed {
    logic             rd;
    logic [IDX_W-1:0] idx;
    logic             ok;
  } cmd_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned N       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_edge.sv
module spi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              wr_o,
  output logic              rd_o,
  output logic [IDX_W-1:0]  addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              miso_o
);
  localparam int unsigned CNT_W  = $clog2(BYTE_W);
  localparam int unsigned IDX_LO = BYTE_W - 1 - IDX_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, wdata_q;
  cmd_t              cmd_q, cmd_d;
  logic              load_q, wr_q, rd_q, miso_q;
  logic [BYTE_W-1:0] byte_in;
  logic              last_bit;

  assign byte_in  = {sh_q[BYTE_W-2:0], mosi_i};
  assign last_bit = (cnt_q == LAST);

  always_comb begin
    cmd_d.rd  = byte_in[BYTE_W-1];
    cmd_d.idx = byte_in[BYTE_W-2 -: IDX_W];
    cmd_d.ok  = ~|byte_in[IDX_LO-1:1];   // reserved pad bits must be zero
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      cmd_q   <= '0;
      load_q  <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      miso_q  <= 1'b0;
    end else begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      load_q <= 1'b0;
      if (!cs_act_i) begin
        phase_q <= PH_CMD;
        cnt_q   <= '0;
        tx_q    <= '0;
        miso_q  <= 1'b0;
      end else begin
        if (load_q) begin
          tx_q <= rdata_i;   // index settled one cycle earlier
          rd_q <= 1'b1;
        end
        if (rise_i && phase_q != PH_DONE) begin
          sh_q  <= byte_in;
          cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
          if (last_bit) begin
            if (phase_q == PH_CMD) begin
              cmd_q   <= cmd_d;
              phase_q <= PH_DATA;
              load_q  <= cmd_d.rd & cmd_d.ok;
            end else begin
              phase_q <= PH_DONE;
              if (!cmd_q.rd && cmd_q.ok) begin
                wr_q    <= 1'b1;
                wdata_q <= byte_in;
              end
            end
          end
        end
        if (fall_i && phase_q != PH_CMD) begin
          miso_q <= tx_q[BYTE_W-1];
          tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign wr_o    = wr_q;
  assign rd_o    = rd_q;
  assign addr_o  = cmd_q.idx;
  assign wdata_o = wdata_q;
  assign miso_o  = miso_q;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_sclk_i,
  input  logic              spi_csn_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic              spi_miso_oe_o,
  output logic [IDX_W-1:0]  reg_addr_o,
  output logic              reg_wr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic [2:0] pins_s;
  logic       sclk_s, csn_s, mosi_s, cs_act;
  logic       sclk_rise, sclk_fall;

  spi_sync #(
    .N       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({spi_csn_i, spi_sclk_i, spi_mosi_i}),
    .q_o    (pins_s)
  );

  assign {csn_s, sclk_s, mosi_s} = pins_s;
  assign cs_act = ~csn_s;

  spi_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sclk_s),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  spi_frame #(.BYTE_W(BYTE_W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (cs_act),
    .rise_i   (sclk_rise),
    .fall_i   (sclk_fall),
    .mosi_i   (mosi_s),
    .rdata_i  (reg_rdata_i),
    .wr_o     (reg_wr_o),
    .rd_o     (reg_rd_o),
    .addr_o   (reg_addr_o),
    .wdata_o  (reg_wdata_o),
    .miso_o   (spi_miso_o)
  );

  // Pad enable follows the raw pin so release is immediate.
  assign spi_miso_oe_o = ~spi_csn_i;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_reg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_act_i,
  input logic             reg_wr_i,
  input logic             reg_rd_i,
  input logic [IDX_W-1:0] reg_addr_i
);
  // R4
  a_r4_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> !reg_wr_i);
  // R4
  a_r4_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |-> $stable(reg_addr_i));
  // R5
  a_r5_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i |=> !reg_rd_i);
  // R5 / R4: one direction per frame
  a_r5_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_rd_i));
  // R7
  a_r7_wr_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |-> cs_act_i);
  // R9
  a_r9_rd_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i |-> cs_act_i);
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_act_i   (cs_act),
  .reg_wr_i   (reg_wr_o),
  .reg_rd_i   (reg_rd_o),
  .reg_addr_i (reg_addr_o)
);

// File: tb/test_spi_reg_slave.sv
`timescale 1ns/1ps
module test_spi_reg_slave;
  localparam int HP = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic       miso, miso_oe, wr, rd;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] rf [16];
  logic [7:0] exp_rf [16];
  int         n_chk = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  spi_reg_slave i_spi_reg_slave (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .spi_sclk_i    (sclk),
    .spi_csn_i     (csn),
    .spi_mosi_i    (mosi),
    .spi_miso_o    (miso),
    .spi_miso_oe_o (miso_oe),
    .reg_addr_o    (addr),
    .reg_wr_o      (wr),
    .reg_wdata_o   (wdata),
    .reg_rd_o      (rd),
    .reg_rdata_i   (rdata)
  );

  assign rdata = rf[addr];

  always @(posedge clk) begin
    if (wr) begin rf[addr] <= wdata; wr_cnt++; end
    if (rd) rd_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cmd byte, then nd bits of dat (MSB first); rx collects MISO at rising edges
  task automatic xfer(input logic [7:0] cmd, input logic [15:0] dat,
                      input int nd, output logic [15:0] rx);
    logic [23:0] bits;
    rx = '0;
    bits = {cmd, dat};
    csn = 1'b0;
    #HP;
    for (int i = 0; i < 8 + nd; i++) begin
      mosi = bits[23-i];
      #HP;
      if (i >= 8 && i < 24) rx[23-i] = miso;
      sclk = 1'b1;
      #HP;
      sclk = 1'b0;
    end
    #HP;
    csn = 1'b1;
    #(2*HP);
  endtask

  function automatic logic [7:0] val_of(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  initial begin
    #(4*150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    int w0, r0;
    for (int a = 0; a < 16; a++) begin rf[a] = 8'h00; exp_rf[a] = 8'h00; end
    #21;
    // R1 reset state
    chk("R1 wr", wr, 0);
    chk("R1 rd", rd, 0);
    chk("R1 miso", miso, 0);
    chk("R1 addr", addr, 0);
    chk("R1 oe", miso_oe, 0);
    rst_n = 1'b1;
    #(8*4 + 1);

    // R2 output enable follows chip select
    csn = 1'b0; #10;
    chk("R2 oe selected", miso_oe, 1);
    csn = 1'b1; #10;
    chk("R2 oe deselected", miso_oe, 0);
    #(2*HP);

    // R9 SCLK with chip select high
    for (int i = 0; i < 6; i++) begin sclk = 1'b1; #HP; sclk = 1'b0; #HP; end
    chk("R9 no write", wr_cnt, 0);
    chk("R9 no read", rd_cnt, 0);

    // R3 / R4 write sweep; bit 0 toggled to show it is ignored
    for (int a = 0; a < 16; a++) begin
      w0 = wr_cnt;
      xfer({1'b0, 4'(a), 2'b00, 1'(a)}, {val_of(a), 8'h00}, 8, rx);
      exp_rf[a] = val_of(a);
      chk("R4 one strobe", wr_cnt - w0, 1);
      chk("R3 reg content", rf[a], exp_rf[a]);
    end

    // R3 / R5 read sweep
    for (int a = 0; a < 16; a++) begin
      r0 = rd_cnt;
      xfer({1'b1, 4'(a), 3'b000}, 16'h0000, 8, rx);
      chk("R5 read byte", rx[15:8], exp_rf[a]);
      chk("R5 one strobe", rd_cnt - r0, 1);
    end

    // R6 rejected commands
    for (int p = 1; p < 4; p++) begin
      w0 = wr_cnt; r0 = rd_cnt;
      xfer({1'b0, 4'd5, 2'(p), 1'b0}, 16'hFF00, 8, rx);
      chk("R6 no write", wr_cnt - w0, 0);
      chk("R6 reg kept", rf[5], exp_rf[5]);
      xfer({1'b1, 4'd5, 2'(p), 1'b0}, 16'h0000, 8, rx);
      chk("R6 zero read", rx[15:8], 0);
      chk("R6 no read strobe", rd_cnt - r0, 0);
    end

    // R7 abort mid data byte, then mid command byte
    w0 = wr_cnt;
    xfer({1'b0, 4'd3, 3'b000}, 16'h5A00, 5, rx);
    chk("R7 no write", wr_cnt - w0, 0);
    xfer(8'h08, 16'h0000, 0, rx);
    csn = 1'b0; #HP;
    for (int i = 0; i < 4; i++) begin mosi = 1'b1; #HP; sclk = 1'b1; #HP; sclk = 1'b0; end
    #HP; csn = 1'b1; #(2*HP);
    xfer({1'b1, 4'd3, 3'b000}, 16'h0000, 8, rx);
    chk("R7 reg kept", rx[15:8], exp_rf[3]);
    chk("R7 no write after abort", wr_cnt - w0, 0);

    // R8 extra bytes ignored
    w0 = wr_cnt;
    xfer({1'b0, 4'd9, 3'b000}, 16'hC3_3C, 16, rx);
    exp_rf[9] = 8'hC3;
    chk("R8 single write", wr_cnt - w0, 1);
    chk("R8 first byte kept", rf[9], exp_rf[9]);
    xfer({1'b1, 4'd9, 3'b000}, 16'h0000, 16, rx);
    chk("R8 read byte", rx[15:8], exp_rf[9]);
    chk("R8 trailing zero", rx[7:0], 0);

    // R9 normal framing after idle clocks
    for (int i = 0; i < 3; i++) begin sclk = 1'b1; #HP; sclk = 1'b0; #HP; end
    xfer({1'b0, 4'd14, 3'b000}, 16'h9600, 8, rx);
    exp_rf[14] = 8'h96;
    xfer({1'b1, 4'd14, 3'b000}, 16'h0000, 8, rx);
    chk("R9 framing intact", rx[15:8], exp_rf[14]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule